// File: doc/BRIEF.md
# Auto-Cycling Plane Latch Loader

This block keeps one foreground latch and one background latch for each video memory plane. The default build has four planes of 8 bits. A host reaches every latch through a small register port. Each latch has its own direct address. There are also two fast-load addresses. Consecutive writes to a fast-load address fill the planes of one bank in turn. A 2-bit pointer inside each bank selects the plane for the next fast write. That pointer advances after every fast write. A read of the same fast-load address sends the pointer back to plane 0. A state register shows both pointers and can be written, so an interrupted load can resume where it stopped.

On the data side, CPU write data travels toward memory as a valid/ready stream with no buffering. The sender holds `cpu_wvalid` with a stable `cpu_wdata` until it sees `cpu_wready` high at a clock edge. A transfer completes on any edge where valid and ready are both high. Back-pressure from memory (`mem_wready` low) reaches `cpu_wready` in the same cycle. When the foreground mode field selects dither, each plane's slot of `mem_wdata` carries that plane's foreground latch instead of the CPU byte. In every other mode the CPU byte is copied to all planes. The background latches are presented continuously on `bg_latches` for the downstream memory logic.

Register address map (default, 4 planes):
- 0 to 3: direct foreground latches for planes 0 to 3.
- 4 to 7: direct background latches for planes 0 to 3.
- 8: foreground fast-load port.
- 9: background fast-load port.
- 10: state register.
- 11: mode register.

Top module: `plane_latch_loader`

## Requirements
- R1: A write to address 8 stores `reg_wdata` into the foreground latch selected by the foreground pointer. On the same edge the pointer increments, wrapping from 3 to 0.
- R2: A write to address 9 stores `reg_wdata` into the background latch selected by the background pointer. On the same edge the pointer increments, wrapping from 3 to 0.
- R3: A read of address 8 or 9 returns the latch that port's pointer selects, combinationally in the strobe cycle. At the clock edge that port's pointer is set to 0.
- R4: Activity on one bank leaves the other bank alone. Fast writes, fast reads and direct writes to one bank never change the other bank's pointer or latches.
- R5: Reading address 10 returns the background pointer in bits 1:0 and the foreground pointer in bits 5:4. Bits 3:2 and 7:6 read as 0. The read has no side effect.
- R6: Writing address 10 loads the background pointer from `reg_wdata[1:0]` and the foreground pointer from `reg_wdata[5:4]`.
- R7: Addresses 0 to 3 read and write foreground latches 0 to 3. Addresses 4 to 7 read and write background latches 0 to 3. These direct accesses never move either pointer.
- R8: Address 11 holds a 2-bit mode in bits 1:0, and its other bits read as 0. When the mode is 2 (dither), `mem_wdata[8p+7:8p]` equals foreground latch p for every plane p.
- R9: When the mode is 0, 1 or 3, every plane slot of `mem_wdata` equals `cpu_wdata`.
- R10: `mem_wvalid` follows `cpu_wvalid` and `cpu_wready` follows `mem_wready`, both in the same cycle.
- R11: After reset, all latches, both pointers and the mode read as 0.
- R12: Addresses 12 to 15 read as 0, and writes to them change no state.
- R13: If `reg_wr` and `reg_rd` are both high in one cycle, the write takes effect and the read side effect does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| cpu_wvalid | input | 1 | CPU write data valid |
| cpu_wready | output | 1 | CPU write data accepted |
| cpu_wdata | input | 8 | CPU write byte |
| mem_wvalid | output | 1 | Plane write data valid |
| mem_wready | input | 1 | Memory side ready |
| mem_wdata | output | 32 | Per-plane write data; plane p in bits 8p+7:8p |
| bg_latches | output | 32 | Background latches; plane p in bits 8p+7:8p |

## Verification
The assertions assume the host uses the register strobes in a defined way. Each strobe is high for a single cycle, and `reg_addr` and `reg_wdata` are stable while it is high. The read-clear assertion only looks at cycles with a read and no write, because a combined strobe is resolved in favour of the write.

The stream assertions assume the dither mode and the foreground latches are not changed while a transfer stalls. They check the per-plane output against the mode held in the design.

The bench drives at most one strobe per cycle, on the falling edge, and keeps every address inside the 4-bit map. It tests the combined-strobe case by name, in a dedicated check.

// File: rtl/pll_pkg.sv
package pll_pkg;

  // Foreground mode encoding that substitutes the latches for CPU data.
  localparam logic [1:0] FGM_DITHER = 2'd2;

  // Per-bank strobes produced by the register decoder.
  typedef struct packed {
    logic dir_we;   // direct write to one plane latch
    logic fast_we;  // write through the auto-cycling port
    logic fast_rd;  // read of the auto-cycling port (clears pointer)
    logic ptr_we;   // pointer load from the state register
  } bank_ctl_t;

endpackage

// File: rtl/pll_reg_decode.sv
module pll_reg_decode
  import pll_pkg::*;
#(
  parameter int unsigned NPLANES = 4,
  parameter int unsigned AW      = 4,
  localparam int unsigned PW     = $clog2(NPLANES)
) (
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  output bank_ctl_t     fg_ctl,
  output bank_ctl_t     bg_ctl,
  output logic [PW-1:0] dir_sel,
  output logic          mode_we
);

  localparam logic [AW-1:0] A_BG0   = AW'(NPLANES);
  localparam logic [AW-1:0] A_FFAST = AW'(2 * NPLANES);
  localparam logic [AW-1:0] A_BFAST = AW'(2 * NPLANES + 1);
  localparam logic [AW-1:0] A_STATE = AW'(2 * NPLANES + 2);
  localparam logic [AW-1:0] A_MODE  = AW'(2 * NPLANES + 3);

  logic rd_eff;
  assign rd_eff  = rd & ~wr;          // a write in the same cycle wins
  assign dir_sel = addr[PW-1:0];      // plane index within either bank

  always_comb begin
    fg_ctl  = '0;
    bg_ctl  = '0;
    mode_we = 1'b0;
    if (addr < A_BG0) begin
      fg_ctl.dir_we = wr;
    end else if (addr < A_FFAST) begin
      bg_ctl.dir_we = wr;
    end else if (addr == A_FFAST) begin
      fg_ctl.fast_we = wr;
      fg_ctl.fast_rd = rd_eff;
    end else if (addr == A_BFAST) begin
      bg_ctl.fast_we = wr;
      bg_ctl.fast_rd = rd_eff;
    end else if (addr == A_STATE) begin
      fg_ctl.ptr_we = wr;
      bg_ctl.ptr_we = wr;
    end else if (addr == A_MODE) begin
      mode_we = wr;
    end
  end

endmodule

// File: rtl/pll_latch_bank.sv
module pll_latch_bank
  import pll_pkg::*;
#(
  parameter int unsigned NPLANES = 4,
  parameter int unsigned DW      = 8,
  localparam int unsigned PW     = $clog2(NPLANES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  bank_ctl_t             ctl,
  input  logic [PW-1:0]         dir_sel,
  input  logic [PW-1:0]         ptr_wdata,
  input  logic [DW-1:0]         wdata,
  output logic [NPLANES*DW-1:0] lat_flat,
  output logic [PW-1:0]         ptr
);

  logic [PW-1:0] ptr_q;

  // Pointer: NPLANES is a power of two, so the increment wraps by itself.
  always_ff @(posedge clk) begin
    if (!rst_n)           ptr_q <= '0;
    else if (ctl.fast_we) ptr_q <= ptr_q + 1'b1;
    else if (ctl.fast_rd) ptr_q <= '0;
    else if (ctl.ptr_we)  ptr_q <= ptr_wdata;
  end

  assign ptr = ptr_q;

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= '0;
      else if (ctl.dir_we && dir_sel == PW'(p))
        q <= wdata;
      else if (ctl.fast_we && ptr_q == PW'(p))
        q <= wdata;
    end
    assign lat_flat[p*DW +: DW] = q;
  end

endmodule

// File: rtl/pll_plane_mux.sv
module pll_plane_mux
  import pll_pkg::*;
#(
  parameter int unsigned NPLANES = 4,
  parameter int unsigned DW      = 8
) (
  input  logic [1:0]            mode,
  input  logic [DW-1:0]         cpu_data,
  input  logic [NPLANES*DW-1:0] fg_flat,
  output logic [NPLANES*DW-1:0] out_flat
);

  logic dither;
  assign dither = (mode == FGM_DITHER);

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    assign out_flat[p*DW +: DW] = dither ? fg_flat[p*DW +: DW] : cpu_data;
  end

endmodule

// File: rtl/plane_latch_loader.sv
module plane_latch_loader
  import pll_pkg::*;
#(
  parameter int unsigned NPLANES = 4,  // power of two, 2 to 16
  parameter int unsigned DW      = 8,  // at least 4 + pointer width
  parameter int unsigned AW      = 4   // holds 2*NPLANES+4 addresses
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [AW-1:0]         reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  input  logic                  cpu_wvalid,
  output logic                  cpu_wready,
  input  logic [DW-1:0]         cpu_wdata,
  output logic                  mem_wvalid,
  input  logic                  mem_wready,
  output logic [NPLANES*DW-1:0] mem_wdata,
  output logic [NPLANES*DW-1:0] bg_latches
);

  localparam int unsigned PW = $clog2(NPLANES);
  localparam int unsigned FG_LSB = 4;   // foreground pointer field in state reg
  localparam logic [AW-1:0] A_BG0   = AW'(NPLANES);
  localparam logic [AW-1:0] A_FFAST = AW'(2 * NPLANES);
  localparam logic [AW-1:0] A_BFAST = AW'(2 * NPLANES + 1);
  localparam logic [AW-1:0] A_STATE = AW'(2 * NPLANES + 2);
  localparam logic [AW-1:0] A_MODE  = AW'(2 * NPLANES + 3);

  bank_ctl_t             fg_ctl, bg_ctl;
  logic [PW-1:0]         dir_sel;
  logic                  mode_we;
  logic [1:0]            mode_q;
  logic [NPLANES*DW-1:0] fg_lat;
  logic [PW-1:0]         fg_ptr, bg_ptr;

  pll_reg_decode #(.NPLANES(NPLANES), .AW(AW)) u_dec (
    .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .fg_ctl(fg_ctl), .bg_ctl(bg_ctl), .dir_sel(dir_sel), .mode_we(mode_we)
  );

  pll_latch_bank #(.NPLANES(NPLANES), .DW(DW)) u_fg (
    .clk(clk), .rst_n(rst_n), .ctl(fg_ctl), .dir_sel(dir_sel),
    .ptr_wdata(reg_wdata[FG_LSB +: PW]), .wdata(reg_wdata),
    .lat_flat(fg_lat), .ptr(fg_ptr)
  );

  pll_latch_bank #(.NPLANES(NPLANES), .DW(DW)) u_bg (
    .clk(clk), .rst_n(rst_n), .ctl(bg_ctl), .dir_sel(dir_sel),
    .ptr_wdata(reg_wdata[PW-1:0]), .wdata(reg_wdata),
    .lat_flat(bg_latches), .ptr(bg_ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= reg_wdata[1:0];
  end

  pll_plane_mux #(.NPLANES(NPLANES), .DW(DW)) u_mux (
    .mode(mode_q), .cpu_data(cpu_wdata), .fg_flat(fg_lat), .out_flat(mem_wdata)
  );

  // Stream passes straight through; no storage on the data path.
  assign mem_wvalid = cpu_wvalid;
  assign cpu_wready = mem_wready;

  // Register read mux.
  always_comb begin
    reg_rdata = '0;
    if (reg_addr < A_BG0)
      reg_rdata = fg_lat[int'(dir_sel)*DW +: DW];
    else if (reg_addr < A_FFAST)
      reg_rdata = bg_latches[int'(dir_sel)*DW +: DW];
    else if (reg_addr == A_FFAST)
      reg_rdata = fg_lat[int'(fg_ptr)*DW +: DW];
    else if (reg_addr == A_BFAST)
      reg_rdata = bg_latches[int'(bg_ptr)*DW +: DW];
    else if (reg_addr == A_STATE) begin
      reg_rdata[PW-1:0]       = bg_ptr;
      reg_rdata[FG_LSB +: PW] = fg_ptr;
    end else if (reg_addr == A_MODE)
      reg_rdata[1:0] = mode_q;
  end

endmodule

// File: rtl/pll_checker.sv
module pll_checker #(
  parameter int unsigned NPLANES = 4,
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 4,
  localparam int unsigned PW     = $clog2(NPLANES)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic                  reg_rd,
  input logic [AW-1:0]         reg_addr,
  input logic [DW-1:0]         reg_wdata,
  input logic [DW-1:0]         reg_rdata,
  input logic [DW-1:0]         cpu_wdata,
  input logic [NPLANES*DW-1:0] mem_wdata,
  input logic [NPLANES*DW-1:0] bg_latches,
  input logic [NPLANES*DW-1:0] fg_lat,
  input logic [PW-1:0]         fg_ptr,
  input logic [PW-1:0]         bg_ptr,
  input logic [1:0]            mode_q
);

  localparam logic [AW-1:0] C_FFAST = AW'(2 * NPLANES);
  localparam logic [AW-1:0] C_BFAST = AW'(2 * NPLANES + 1);
  localparam logic [AW-1:0] C_STATE = AW'(2 * NPLANES + 2);

  logic wr_ff, wr_bf, rd_ff, rd_bf;
  assign wr_ff = reg_wr && reg_addr == C_FFAST;
  assign wr_bf = reg_wr && reg_addr == C_BFAST;
  assign rd_ff = reg_rd && !reg_wr && reg_addr == C_FFAST;
  assign rd_bf = reg_rd && !reg_wr && reg_addr == C_BFAST;

  logic [DW-1:0] st_exp;
  always_comb begin
    st_exp = '0;
    st_exp[PW-1:0] = bg_ptr;
    st_exp[4 +: PW] = fg_ptr;
  end

  AST_FG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ff |=> fg_ptr == $past(fg_ptr) + 1'b1);                          // R1
  AST_BG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bf |=> bg_ptr == $past(bg_ptr) + 1'b1);                          // R2

  for (genvar p = 0; p < NPLANES; p++) begin : g_load
    AST_FG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ff && fg_ptr == PW'(p)) |=> fg_lat[p*DW +: DW] == $past(reg_wdata));     // R1
    AST_BG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bf && bg_ptr == PW'(p)) |=> bg_latches[p*DW +: DW] == $past(reg_wdata)); // R2
  end

  AST_FG_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ff |=> fg_ptr == '0);                                             // R3
  AST_BG_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bf |=> bg_ptr == '0);                                             // R3
  AST_FG_INDEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ff || rd_ff) |=> $stable(bg_ptr) && $stable(bg_latches));       // R4
  AST_BG_INDEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bf || rd_bf) |=> $stable(fg_ptr) && $stable(fg_lat));           // R4
  AST_STATE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == C_STATE) |-> reg_rdata == st_exp);           // R5
  AST_DITHER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2) |-> mem_wdata == fg_lat);                          // R8
  AST_PASS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'd2) |-> mem_wdata == {NPLANES{cpu_wdata}});            // R9

endmodule

bind plane_latch_loader pll_checker #(.NPLANES(NPLANES), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .cpu_wdata(cpu_wdata), .mem_wdata(mem_wdata), .bg_latches(bg_latches),
  .fg_lat(fg_lat), .fg_ptr(fg_ptr), .bg_ptr(bg_ptr), .mode_q(mode_q)
);

// File: tb/plane_latch_loader_tb.sv
module plane_latch_loader_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        cpu_wvalid = 1'b0, cpu_wready, mem_wvalid, mem_wready = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [31:0] mem_wdata, bg_latches;

  always #10 clk = ~clk;  // 50 MHz

  plane_latch_loader u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_wvalid(cpu_wvalid), .cpu_wready(cpu_wready), .cpu_wdata(cpu_wdata),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_wdata(mem_wdata),
    .bg_latches(bg_latches)
  );

  int checks = 0, errors = 0;
  logic [7:0] mfg [4];
  logic [7:0] mbg [4];
  logic [1:0] mfp = 0, mbp = 0, mmode = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fg_pack();
    return {mfg[3], mfg[2], mfg[1], mfg[0]};
  endfunction
  function automatic logic [31:0] bg_pack();
    return {mbg[3], mbg[2], mbg[1], mbg[0]};
  endfunction

  // Model of a register write, from the requirements.
  task automatic model_wr(logic [3:0] a, logic [7:0] d);
    if (a < 4) mfg[a[1:0]] = d;
    else if (a < 8) mbg[a[1:0]] = d;
    else if (a == 8) begin mfg[mfp] = d; mfp = mfp + 1'b1; end
    else if (a == 9) begin mbg[mbp] = d; mbp = mbp + 1'b1; end
    else if (a == 10) begin mbp = d[1:0]; mfp = d[5:4]; end
    else if (a == 11) mmode = d[1:0];
  endtask

  function automatic logic [7:0] model_rd(logic [3:0] a);
    if (a < 4) return mfg[a[1:0]];
    if (a < 8) return mbg[a[1:0]];
    if (a == 8) return mfg[mfp];
    if (a == 9) return mbg[mbp];
    if (a == 10) return {2'b00, mfp, 2'b00, mbp};
    if (a == 11) return {6'b0, mmode};
    return 8'h00;
  endfunction

  // All tasks start and end on a falling edge.
  task automatic wr(logic [3:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    model_wr(a, d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, string req);
    reg_rd = 1'b1; reg_addr = a;
    #2 check(req, {24'b0, reg_rdata}, {24'b0, model_rd(a)});
    if (a == 8) mfp = 0;
    if (a == 9) mbp = 0;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mfg[i] = 0; mbg[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state on every address; R12 holes read zero.
    for (int a = 0; a < 16; a++) rd(4'(a), "R11");

    // R1: nine fast foreground writes wrap the pointer; R4: bg pointer untouched.
    for (int k = 0; k < 9; k++) begin
      wr(4'd8, 8'(k * 17 + 3));
      rd(4'd10, "R1");
    end
    for (int a = 0; a < 4; a++) rd(4'(a), "R1");
    check("R4", bg_latches, 32'h0);
    // R2: background fast writes; fg state stays put.
    for (int k = 0; k < 6; k++) begin
      wr(4'd9, 8'(8'hA0 + k));
      rd(4'd10, "R2");
    end
    for (int a = 4; a < 8; a++) rd(4'(a), "R2");
    rd(4'd8, "R4");
    // R3: reads of fast ports clear only their own pointer.
    wr(4'd10, 8'h23);
    rd(4'd9, "R3");
    rd(4'd10, "R3");
    rd(4'd8, "R3");
    rd(4'd10, "R3");

    // R5 and R6: full sweep of state-register write values.
    for (int v = 0; v < 256; v++) begin
      wr(4'd10, 8'(v));
      rd(4'd10, "R6");
      rd(4'd10, "R5");
    end
    // R6: a resumed load lands in the plane the pointer names.
    for (int p = 0; p < 4; p++) begin
      wr(4'd10, {2'b00, 2'(p), 2'b00, 2'(3 - p)});
      wr(4'd8, 8'(8'h50 + p));
      wr(4'd9, 8'(8'h60 + p));
      rd(4'(p), "R6");
      rd(4'(4 + (3 - p)), "R6");
    end

    // R7: direct writes do not move pointers.
    wr(4'd10, 8'h12);
    for (int a = 0; a < 8; a++) begin
      wr(4'(a), 8'(8'hC0 + a));
      rd(4'd10, "R7");
    end
    for (int a = 0; a < 8; a++) rd(4'(a), "R7");
    check("R7", bg_latches, bg_pack());

    // R12: writes to unmapped addresses change nothing.
    for (int a = 12; a < 16; a++) wr(4'(a), 8'hFF);
    for (int a = 0; a < 12; a++) rd(4'(a), "R12");

    // R13: combined strobe on a fast port: write wins, no clear.
    wr(4'd10, 8'h00);
    reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = 4'd8; reg_wdata = 8'h77;
    model_wr(4'd8, 8'h77);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    rd(4'd10, "R13");
    rd(4'd0, "R13");

    // R8 and R9: mode sweep against all CPU bytes.
    for (int m = 0; m < 4; m++) begin
      wr(4'd11, 8'(8'hFC | m));
      rd(4'd11, "R8");
      for (int c = 0; c < 256; c++) begin
        cpu_wdata = 8'(c);
        #1;
        if (m == 2) check("R8", mem_wdata, fg_pack());
        else        check("R9", mem_wdata, {4{8'(c)}});
      end
      @(negedge clk);
    end

    // R10: handshake pass-through.
    for (int v = 0; v < 2; v++)
      for (int r = 0; r < 2; r++) begin
        cpu_wvalid = 1'(v); mem_wready = 1'(r);
        #1;
        check("R10", {30'b0, mem_wvalid, cpu_wready}, {30'b0, 1'(v), 1'(r)});
      end

    // Mixed random traffic against the model.
    for (int i = 0; i < 3000; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      cpu_wdata = lfsr[23:16];
      if (lfsr[12]) rd(lfsr[3:0], "R4");
      else wr(lfsr[3:0], lfsr[11:4]);
      check("R4", bg_latches, bg_pack());
      if (mmode == 2) check("R8", mem_wdata, fg_pack());
      else            check("R9", mem_wdata, {4{cpu_wdata}});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule